// File: doc/BRIEF.md
# Multithreaded Issue Thread Selector

This block sits in front of a shared instruction pipeline and decides, every clock, which hardware thread context provides the next instruction. It holds one program counter per context. Each context has three inputs: a ready flag, a short-hazard stall and a long-latency stall such as a second-level cache miss. The block presents a registered thread number, that thread's PC and a valid flag. When the pipeline takes the offered instruction, that thread's PC moves on by one instruction step.

There are two scheduling modes, chosen by one input. In interleaved mode the offered thread rotates round-robin every cycle, and any thread that is stalled is skipped. In blocked mode one owner thread keeps issuing until it raises its long-stall input. Short hazards only cost idle cycles. On a long stall, ownership moves to another context and a fixed switch penalty of idle cycles follows.

Top module: `mtis_thread_sel`

## Requirements
- R1: After a synchronous reset, issue_valid is low and thread t's PC is START_BASE + t*START_STRIDE. The first interleaved search starts at thread 0, and the blocked-mode owner is thread 0.
- R2: In interleaved mode (coarse_mode = 0), the offered thread is the first eligible thread found by searching upward with wrap-around, starting after the thread whose issue was most recently accepted. A thread is eligible when ready = 1, hazard = 0 and miss = 0.
- R3: In interleaved mode, a thread that has either its hazard bit or its miss bit set is never offered.
- R4: If no thread is eligible when a new selection is made, issue_valid is low in the following cycle and no PC changes.
- R5: issue_pc equals the offered thread's current PC. When issue_valid and issue_accept are both high, that thread's PC grows by PC_STEP and every other PC keeps its value.
- R6: While issue_valid is high and issue_accept is low, the offer holds: valid, thread and PC stay unchanged in the next cycle and no PC changes.
- R7: In blocked mode (coarse_mode = 1), only the owner thread is offered. It is offered whenever it is eligible. A hazard on the owner gives an idle cycle but keeps the same owner.
- R8: In blocked mode, a miss on the owner moves ownership to the first thread after it, in wrap-around order, whose miss bit is low. If every miss bit is set, ownership moves to the owner's successor. The output is invalid for exactly SWITCH_PENALTY cycles from that decision before the new owner can be offered.
- R9: Outputs are registered: a selection uses the inputs present at a clock edge and appears right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coarse_mode | input | 1 | 0 = interleaved every cycle, 1 = blocked until long stall |
| thr_ready | input | NUM_THREADS | Per-thread context has work |
| thr_hazard | input | NUM_THREADS | Per-thread short-hazard stall |
| thr_miss | input | NUM_THREADS | Per-thread long-latency stall |
| issue_accept | input | 1 | Pipeline takes the offered instruction |
| issue_valid | output | 1 | An instruction is offered |
| issue_tid | output | $clog2(NUM_THREADS) | Offered thread number |
| issue_pc | output | PC_W | Offered thread's PC |

## Verification
The hardest case to reach is a long stall on the blocked-mode owner at a moment when every other context also has its miss bit set. A closely related case is a miss that arrives while a switch penalty is still running. In both, the ownership target and the idle window depend on the owner's identity, which is internal state. The bench keeps its own arithmetic record of ownership and aims miss bits at the owner it predicts. Some of those aimed bursts set all miss bits at once. Others keep misses raised through the penalty, so both the fallback target and the idle count can be checked against a port-level prediction.

// File: rtl/mtis_pkg.sv
package mtis_pkg;
  typedef enum logic {
    SEL_INTERLEAVE = 1'b0,
    SEL_BLOCKED    = 1'b1
  } sel_mode_e;
endpackage

// File: rtl/mtis_rr_pick.sv
module mtis_rr_pick #(
  parameter int N  = 4,
  parameter int TW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [TW-1:0] after,
  output logic          found,
  output logic [TW-1:0] idx
);
  // Iterate from farthest to nearest so the nearest requester wins.
  always_comb begin
    found = 1'b0;
    idx   = after;
    for (int k = N; k >= 1; k--) begin
      int c;
      c = int'(after) + k;
      if (c >= N) c = c - N;
      if (req[c]) begin
        found = 1'b1;
        idx   = TW'(c);
      end
    end
  end
endmodule

// File: rtl/mtis_pc_bank.sv
module mtis_pc_bank #(
  parameter int               N      = 4,
  parameter int               TW     = 2,
  parameter int               PW     = 32,
  parameter int unsigned      STEP   = 4,
  parameter logic [PW-1:0]    BASE   = '0,
  parameter int unsigned      STRIDE = 32'h100
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic [TW-1:0]        adv_tid,
  output logic [N-1:0][PW-1:0] pc_nxt
);
  logic [N-1:0][PW-1:0] pc_q;

  for (genvar i = 0; i < N; i++) begin : g_ctx
    always_comb begin
      pc_nxt[i] = pc_q[i];
      if (adv && adv_tid == TW'(i)) pc_nxt[i] = pc_q[i] + PW'(STEP);
    end

    always_ff @(posedge clk) begin
      if (rst) pc_q[i] <= BASE + PW'(i * STRIDE);
      else     pc_q[i] <= pc_nxt[i];
    end

    // R5: a context's PC never moves unless that context's issue is taken
    a_r5_pc_still: assert property (@(posedge clk) disable iff (rst)
      !(adv && adv_tid == TW'(i)) |=> pc_q[i] == $past(pc_q[i]));
  end
endmodule

// File: rtl/mtis_thread_sel.sv
module mtis_thread_sel
  import mtis_pkg::*;
#(
  parameter int               NUM_THREADS    = 4,
  parameter int               PC_W           = 32,
  parameter int unsigned      PC_STEP        = 4,
  parameter int               SWITCH_PENALTY = 2,
  parameter logic [PC_W-1:0]  START_BASE     = '0,
  parameter int unsigned      START_STRIDE   = 32'h100,
  localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   coarse_mode,
  input  logic [NUM_THREADS-1:0] thr_ready,
  input  logic [NUM_THREADS-1:0] thr_hazard,
  input  logic [NUM_THREADS-1:0] thr_miss,
  input  logic                   issue_accept,
  output logic                   issue_valid,
  output logic [TW-1:0]          issue_tid,
  output logic [PC_W-1:0]        issue_pc
);
  localparam int CW = $clog2(SWITCH_PENALTY + 1);
  localparam logic [TW-1:0] LAST_TID = TW'(NUM_THREADS - 1);

  sel_mode_e mode;
  logic fire, hold;
  logic [NUM_THREADS-1:0] elig;
  logic [TW-1:0] last_q, last_n, owner_q, owner_succ, target;
  logic [CW-1:0] cnt_q;
  logic f_found, t_found;
  logic [TW-1:0] f_idx, t_idx;
  logic [NUM_THREADS-1:0][PC_W-1:0] pc_nxt;

  assign mode   = sel_mode_e'(coarse_mode);
  assign fire   = issue_valid & issue_accept;
  assign hold   = issue_valid & ~issue_accept;
  assign elig   = thr_ready & ~thr_hazard & ~thr_miss;
  assign last_n = fire ? issue_tid : last_q;
  assign owner_succ = (owner_q == LAST_TID) ? '0 : owner_q + 1'b1;
  assign target = t_found ? t_idx : owner_succ;

  mtis_rr_pick #(.N(NUM_THREADS), .TW(TW)) u_pick_fine (
    .req(elig), .after(last_n), .found(f_found), .idx(f_idx)
  );

  mtis_rr_pick #(.N(NUM_THREADS), .TW(TW)) u_pick_target (
    .req(~thr_miss), .after(owner_q), .found(t_found), .idx(t_idx)
  );

  mtis_pc_bank #(
    .N(NUM_THREADS), .TW(TW), .PW(PC_W), .STEP(PC_STEP),
    .BASE(START_BASE), .STRIDE(START_STRIDE)
  ) u_pcs (
    .clk(clk), .rst(rst), .adv(fire), .adv_tid(issue_tid), .pc_nxt(pc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid <= 1'b0;
      issue_tid   <= '0;
      issue_pc    <= '0;
      last_q      <= LAST_TID;
      owner_q     <= '0;
      cnt_q       <= '0;
    end else begin
      last_q <= last_n;
      if (!hold) begin
        if (mode == SEL_INTERLEAVE) begin
          cnt_q       <= '0;
          issue_valid <= f_found;
          issue_tid   <= f_idx;
          issue_pc    <= pc_nxt[f_idx];
        end else if (cnt_q != '0) begin
          issue_valid <= 1'b0;
          cnt_q       <= cnt_q - 1'b1;
        end else if (thr_miss[owner_q]) begin
          issue_valid <= 1'b0;
          owner_q     <= target;
          cnt_q       <= CW'(SWITCH_PENALTY - 1);
        end else begin
          issue_valid <= elig[owner_q];
          issue_tid   <= owner_q;
          issue_pc    <= pc_nxt[owner_q];
        end
      end
    end
  end

  // R6: a refused offer is held unchanged
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    hold |=> issue_valid && $stable(issue_tid) && $stable(issue_pc));

  // R4: nothing eligible at a fresh selection gives an idle cycle
  a_r4_idle: assert property (@(posedge clk) disable iff (rst)
    !hold && elig == '0 |=> !issue_valid);

  // R3: anything offered was eligible when it was chosen
  a_r3_skip_stalled: assert property (@(posedge clk) disable iff (rst)
    !hold |=> !issue_valid || (|(($past(elig) >> issue_tid) & NUM_THREADS'(1))));

  // R8: a miss on the owner in blocked mode starts an idle window
  a_r8_switch_idle: assert property (@(posedge clk) disable iff (rst)
    !hold && coarse_mode && cnt_q == '0 && thr_miss[owner_q] |=> !issue_valid);

  // R5: back-to-back taken issues of one thread step its PC
  a_r5_pc_step: assert property (@(posedge clk) disable iff (rst)
    fire |=> !(issue_valid && issue_tid == $past(issue_tid))
             || issue_pc == $past(issue_pc) + PC_W'(PC_STEP));

  // R1: first cycle out of reset offers nothing
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !issue_valid);
endmodule

// File: tb/mtis_thread_sel_test.sv
module mtis_thread_sel_test;
  localparam int N = 4;
  localparam int PW = 32;
  localparam int STEP = 4;
  localparam int PEN = 2;
  localparam logic [31:0] BASE = 32'h1000;
  localparam int STRIDE = 32'h100;
  localparam real HALF = 10.0;

  logic clk = 1'b0, rst = 1'b1, coarse_mode = 1'b0, issue_accept = 1'b0;
  logic [N-1:0] thr_ready = '0, thr_hazard = '0, thr_miss = '0;
  logic issue_valid;
  logic [1:0] issue_tid;
  logic [PW-1:0] issue_pc;

  int checks = 0, failures = 0;
  bit done = 0;

  // model state
  bit m_valid;
  int m_tid, m_last, m_owner, m_cnt;
  logic [31:0] m_pc;
  logic [31:0] m_pcs [N];

  always #(HALF) clk = ~clk;

  mtis_thread_sel #(
    .NUM_THREADS(N), .PC_W(PW), .PC_STEP(STEP), .SWITCH_PENALTY(PEN),
    .START_BASE(BASE), .START_STRIDE(STRIDE)
  ) uut (
    .clk(clk), .rst(rst), .coarse_mode(coarse_mode), .thr_ready(thr_ready),
    .thr_hazard(thr_hazard), .thr_miss(thr_miss), .issue_accept(issue_accept),
    .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_pc(issue_pc)
  );

  task automatic model_reset();
    m_valid = 0; m_tid = 0; m_pc = '0; m_last = N - 1; m_owner = 0; m_cnt = 0;
    for (int t = 0; t < N; t++) m_pcs[t] = BASE + t * STRIDE;
  endtask

  // one clock edge of the expected behaviour, from the requirements
  task automatic model_step(logic [N-1:0] rdy, logic [N-1:0] hz, logic [N-1:0] ms,
                            bit md, bit acc);
    logic [N-1:0] el;
    int tgt;
    el = rdy & ~hz & ~ms;
    if (m_valid && !acc) return;
    if (m_valid) begin
      m_pcs[m_tid] = m_pcs[m_tid] + STEP;
      m_last = m_tid;
    end
    if (!md) begin
      m_cnt = 0; m_valid = 0;
      for (int k = 1; k <= N; k++) begin
        int c;
        c = (m_last + k) % N;
        if (!m_valid && el[c]) begin m_valid = 1; m_tid = c; m_pc = m_pcs[c]; end
      end
    end else if (m_cnt != 0) begin
      m_valid = 0; m_cnt--;
    end else if (ms[m_owner]) begin
      m_valid = 0;
      tgt = (m_owner + 1) % N;
      for (int k = N; k >= 1; k--) begin
        int c;
        c = (m_owner + k) % N;
        if (!ms[c]) tgt = c;
      end
      m_owner = tgt; m_cnt = PEN - 1;
    end else begin
      m_valid = el[m_owner];
      if (m_valid) begin m_tid = m_owner; m_pc = m_pcs[m_owner]; end
    end
  endtask

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, then compare at the next falling edge
  task automatic cyc(logic [N-1:0] rdy, logic [N-1:0] hz, logic [N-1:0] ms,
                     bit md, bit acc, string req);
    thr_ready = rdy; thr_hazard = hz; thr_miss = ms;
    coarse_mode = md; issue_accept = acc; rst = 1'b0;
    model_step(rdy, hz, ms, md, acc);
    @(negedge clk);
    check(issue_valid == m_valid, req, "valid", issue_valid, m_valid);
    if (m_valid) begin
      check(issue_tid == 2'(m_tid), req, "tid", issue_tid, m_tid);
      check(issue_pc == m_pc, "R5", "pc", issue_pc, m_pc);
    end
  endtask

  initial begin
    #(HALF * 2 * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check(issue_valid == 1'b0, "R1", "valid in reset", issue_valid, 0);

    // R1/R2: first offer is thread 0 at its start PC, then rotation
    cyc('1, '0, '0, 0, 1, "R1");
    check(issue_pc == BASE, "R1", "start pc t0", issue_pc, BASE);
    for (int i = 0; i < 9; i++) cyc('1, '0, '0, 0, 1, "R2");

    // R3/R4: every eligibility pattern, stalls split between both kinds
    for (int p = 0; p < 16; p++)
      for (int r = 0; r < 3; r++)
        cyc('1, 4'(~p) & 4'b0101, 4'(~p) & 4'b1010, 0, 1, (p == 0) ? "R4" : "R3");

    // R4: ready low everywhere
    for (int i = 0; i < 3; i++) cyc('0, '0, '0, 0, 1, "R4");

    // R6: random refusal of offers in interleaved mode
    for (int i = 0; i < 60; i++)
      cyc('1, 4'($urandom) & 4'($urandom), '0, 0, 1'($urandom), "R6");

    // R9: registered selection with random traffic
    for (int i = 0; i < 100; i++)
      cyc(4'($urandom) | 4'($urandom), 4'($urandom) & 4'($urandom),
          4'($urandom) & 4'($urandom), 0, 1'($urandom % 4 != 0), "R9");

    // R7: blocked mode, hazards only
    for (int i = 0; i < 60; i++)
      cyc('1, 4'($urandom) & 4'($urandom), '0, 1, 1'($urandom % 4 != 0), "R7");

    // R8: misses aimed at the predicted owner, including all-miss bursts
    for (int i = 0; i < 300; i++) begin
      logic [N-1:0] ms;
      int sel;
      sel = $urandom % 6;
      ms = '0;
      if (sel == 0) ms = 4'(1 << m_owner);
      else if (sel == 1) ms = '1;
      else if (sel == 2) ms = 4'(1 << m_owner) | 4'(1 << ((m_owner + 1) % N));
      else if (sel == 3) ms = 4'($urandom);
      cyc('1, 4'($urandom) & 4'($urandom) & 4'($urandom), ms, 1,
          1'($urandom % 5 != 0), "R8");
    end

    // R2/R7: mode changes mixed with everything
    for (int i = 0; i < 400; i++)
      cyc(4'($urandom) | 4'($urandom), 4'($urandom) & 4'($urandom),
          4'($urandom) & 4'($urandom) & 4'($urandom),
          1'($urandom % 8 < 5), 1'($urandom % 4 != 0), "R2");

    // R1: reset mid-run restores start state
    rst = 1'b1;
    model_reset();
    repeat (2) @(negedge clk);
    check(issue_valid == 1'b0, "R1", "valid after reset", issue_valid, 0);
    cyc(4'b0100, '0, '0, 0, 1, "R1");
    check(issue_pc == BASE + 2 * STRIDE, "R1", "start pc t2", issue_pc, BASE + 2 * STRIDE);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule